// File: doc/BRIEF.md
# Scatter-Gather Bus-Master DMA Engine

This block moves data between a disk-style device stream and system memory by walking a table of memory-resident descriptors. Software fills the table, points the engine at it through a three-register window, programs the device side with a sector count and then sets the start bit. The engine fetches each 8-byte descriptor, copies 32-bit words between the device stream and the buffer that the descriptor names, and moves on until either the device has delivered or accepted its whole transfer or the table runs out.

The way the run ends is reported in the status register and on the interrupt line, and the outcome differs by case:
- If the table and the device transfer end together, the result is interrupt with the engine idle.
- If the table is too short, the engine goes idle silently.
- If the table is longer than the transfer, both active and interrupt are set until software stops the engine.

A memory error response halts the run and raises error and interrupt. A software stop clears active and leaves the interrupt bit as it was.

The memory side is a word-wide request port that holds each request until it is acknowledged. The device side is a pair of valid/ready word streams, one for each direction. The device's total length is given as a sector count, at 512 bytes per sector.

Top module: `sg_dma_engine`

## Requirements
- R1: After reset the command, status and table-base registers read 0, `irq` is low and no memory request is made.
- R2: Register window: the command register is at offset 0, with bit 0 = run and bit 3 = direction. The status register is at offset 2, with bit 0 = active, bit 1 = error and bit 2 = interrupt. The table base is at offset 4 and is word aligned, so bits 1:0 read 0. All three registers read back.
- R3: A run starts when run is written 1 while it reads 0. Descriptors are fetched in order from the table base with a stride of 8 bytes. The first word of a descriptor is the buffer address. In the second word, bits 15:0 hold the byte count and bit 31 marks the last descriptor. Each buffer is moved in rising word order, and the device length is the sector count × 512 bytes.
- R4: A descriptor byte count of 0 stands for 65536 bytes.
- R5: If the device transfer ends exactly at the end of the last descriptor, the status becomes 4: interrupt set, active clear.
- R6: If the last descriptor is used up before the device transfer ends, the status becomes 0, and memory beyond the table's last byte is not written.
- R7: If the device transfer ends while table space remains, the status becomes 5 (active and interrupt) and stays so. Table space remains when the current descriptor has bytes left or is not the last one.
- R8: Writing 0 to run clears active at the next edge and leaves interrupt unchanged. A stop after R7 gives status 4. A stop in the middle of a run gives 0 and consumes no further device words.
- R9: Writing 1 to status bit 1 or bit 2 clears that bit.
- R10: An error response from memory sets error and interrupt, clears active and ends all memory requests.
- R11: `irq` equals status bit 2 on every cycle.
- R12: Direction 1 moves words from the device into memory and only issues memory writes for data. Direction 0 reads memory and hands the words to the device.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from `reg_addr`) |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address (word aligned) |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_err | input | 1 | Error response, valid with `mem_ack` |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| dev_sectors | input | SEC_W | Device transfer length in sectors, sampled at start |
| dev_in_valid | input | 1 | Device-to-memory word valid |
| dev_in_data | input | 32 | Device-to-memory word |
| dev_in_ready | output | 1 | Engine accepts the device word |
| dev_out_valid | output | 1 | Memory-to-device word valid |
| dev_out_data | output | 32 | Memory-to-device word |
| dev_out_ready | input | 1 | Device accepts the word |
| irq | output | 1 | Interrupt level |

## Verification
Register reads are combinational, so the bench samples `reg_rdata` a moment after setting the offset in the same cycle. A write takes effect at the next rising edge. A stop and an error response therefore change active by the first edge after the stimulus, and the bench samples status one cycle later.

The end status of a run is set at the edge that follows the last memory acknowledge or device handshake. The bench polls status every cycle, as driver software would, until active falls or interrupt rises, and on each poll compares `irq` with bit 2. A behavioural model walks the same descriptor table and predicts the final status, the exact words and addresses moved, and the number of device words used.

// File: rtl/sg_dma_engine.sv
module sg_dma_engine #(
  parameter int SEC_W        = 8,
  parameter int SECTOR_BYTES = 512
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [2:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             mem_req,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic             mem_ack,
  input  logic             mem_err,
  input  logic [31:0]      mem_rdata,
  input  logic [SEC_W-1:0] dev_sectors,
  input  logic             dev_in_valid,
  input  logic [31:0]      dev_in_data,
  output logic             dev_in_ready,
  output logic             dev_out_valid,
  output logic [31:0]      dev_out_data,
  input  logic             dev_out_ready,
  output logic             irq
);
  localparam int SEC_SH = $clog2(SECTOR_BYTES / 4);
  localparam int DEV_W  = SEC_W + SEC_SH;

  typedef enum logic [2:0] {S_IDLE, S_FADDR, S_FCNT, S_DECIDE, S_MWR, S_MRD, S_DOUT, S_HOLD} state_t;
  state_t state;

  logic             run_q, dir_q, active_q, err_q, intr_q, last_q;
  logic [31:0]      base_q, ptr_q, buf_q, data_q;
  logic [14:0]      drem_q;
  logic [DEV_W-1:0] vrem_q;

  wire wr_cmd  = reg_wr && reg_addr == 3'd0;
  wire wr_sts  = reg_wr && reg_addr == 3'd2;
  wire wr_base = reg_wr && reg_addr == 3'd4;
  wire go      = wr_cmd && reg_wdata[0] && !run_q;
  wire stop    = wr_cmd && !reg_wdata[0] && run_q;

  wire [DEV_W-1:0] dev_words = {dev_sectors, {SEC_SH{1'b0}}};
  wire [16:0]      cnt_bytes = (mem_rdata[15:0] == 16'd0) ? 17'h10000 : {1'b0, mem_rdata[15:0]};

  assign mem_req   = state == S_FADDR || state == S_FCNT || state == S_MWR || state == S_MRD;
  assign mem_we    = state == S_MWR;
  assign mem_addr  = (state == S_FADDR) ? ptr_q : (state == S_FCNT) ? ptr_q + 32'd4 : buf_q;
  assign mem_wdata = data_q;

  wire resp_ok  = mem_req && mem_ack && !mem_err;
  wire resp_bad = mem_req && mem_ack && mem_err;
  wire can_move = vrem_q != '0 && drem_q != 15'd0;

  assign dev_in_ready  = state == S_DECIDE && dir_q && can_move;
  assign dev_out_valid = state == S_DOUT;
  assign dev_out_data  = data_q;
  assign irq           = intr_q;

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {28'd0, dir_q, 2'b00, run_q};
      3'd2:    reg_rdata = {29'd0, intr_q, err_q, active_q};
      3'd4:    reg_rdata = base_q;
      default: reg_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      run_q <= 1'b0; dir_q <= 1'b0; active_q <= 1'b0; err_q <= 1'b0; intr_q <= 1'b0;
      last_q <= 1'b0; base_q <= '0; ptr_q <= '0; buf_q <= '0; data_q <= '0;
      drem_q <= '0; vrem_q <= '0;
    end else begin
      if (wr_cmd) begin
        run_q <= reg_wdata[0];
        if (!active_q) dir_q <= reg_wdata[3];
      end
      if (wr_base) base_q <= {reg_wdata[31:2], 2'b00};
      if (wr_sts) begin
        if (reg_wdata[1]) err_q  <= 1'b0;
        if (reg_wdata[2]) intr_q <= 1'b0;
      end
      if (stop) begin
        state    <= S_IDLE;
        active_q <= 1'b0;
      end else if (go) begin
        state    <= S_FADDR;
        active_q <= 1'b1;
        ptr_q    <= base_q;
        vrem_q   <= dev_words;
      end else if (resp_bad) begin
        state    <= S_IDLE;
        active_q <= 1'b0;
        err_q    <= 1'b1;
        intr_q   <= 1'b1;
      end else begin
        case (state)
          S_FADDR: if (resp_ok) begin
            buf_q <= {mem_rdata[31:2], 2'b00};
            state <= S_FCNT;
          end
          S_FCNT: if (resp_ok) begin
            drem_q <= cnt_bytes[16:2];
            last_q <= mem_rdata[31];
            ptr_q  <= ptr_q + 32'd8;
            state  <= S_DECIDE;
          end
          S_DECIDE: begin
            if (vrem_q == '0) begin
              intr_q <= 1'b1;
              if (drem_q == 15'd0 && last_q) begin
                active_q <= 1'b0;
                state    <= S_IDLE;
              end else begin
                state <= S_HOLD;
              end
            end else if (drem_q == 15'd0) begin
              if (last_q) begin
                active_q <= 1'b0;
                state    <= S_IDLE;
              end else begin
                state <= S_FADDR;
              end
            end else if (!dir_q) begin
              state <= S_MRD;
            end else if (dev_in_valid) begin
              data_q <= dev_in_data;
              state  <= S_MWR;
            end
          end
          S_MWR: if (resp_ok) begin
            drem_q <= drem_q - 15'd1;
            vrem_q <= vrem_q - 1'b1;
            buf_q  <= buf_q + 32'd4;
            state  <= S_DECIDE;
          end
          S_MRD: if (resp_ok) begin
            data_q <= mem_rdata;
            state  <= S_DOUT;
          end
          S_DOUT: if (dev_out_ready) begin
            drem_q <= drem_q - 15'd1;
            vrem_q <= vrem_q - 1'b1;
            buf_q  <= buf_q + 32'd4;
            state  <= S_DECIDE;
          end
          S_HOLD:  state <= S_HOLD;
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  p_write_needs_d2m_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> dir_q);

  p_dev_in_needs_d2m_r12: assert property (@(posedge clk) disable iff (!rst_n)
    dev_in_ready |-> (dir_q && active_q));

  p_req_while_active_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> active_q);

  p_err_halts_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && mem_err && !stop) |=> (!active_q && err_q && intr_q && !mem_req));

  p_stop_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (!active_q && !mem_req));

  p_stop_keeps_intr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !wr_sts) |=> (intr_q == $past(intr_q)));
endmodule

// File: tb/test_sg_dma_engine.sv
module test_sg_dma_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we, mem_ack, mem_err;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [7:0]  dev_sectors = 8'd0;
  logic        dev_in_ready, dev_out_valid;
  logic [31:0] dev_in_data, dev_out_data;

  always #2 clk = ~clk;

  sg_dma_engine i_sg_dma_engine (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
    .dev_sectors(dev_sectors), .dev_in_valid(1'b1), .dev_in_data(dev_in_data),
    .dev_in_ready(dev_in_ready), .dev_out_valid(dev_out_valid), .dev_out_data(dev_out_data),
    .dev_out_ready(1'b1), .irq(irq));

  logic        irq;
  logic [31:0] mem [0:16383];
  logic        ack_q = 1'b0;
  int          in_idx = 0;
  logic [31:0] out_q[$];
  logic [31:0] exp_addr[$];
  int          tests = 0, fails = 0;

  assign mem_ack     = ack_q;
  assign mem_err     = ack_q && mem_addr[31];
  assign mem_rdata   = mem[mem_addr[15:2]];
  assign dev_in_data = 32'hA500_0000 + in_idx;

  always @(posedge clk) begin
    if (mem_req && ack_q && mem_we && !mem_addr[31]) mem[mem_addr[15:2]] = mem_wdata;
    if (dev_out_valid) out_q.push_back(dev_out_data);
  end
  always @(posedge clk) begin
    ack_q  <= mem_req && !ack_q;
    if (dev_in_ready) in_idx <= in_idx + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic desc(input int tbl, input int n, input logic [31:0] a, input logic [31:0] c);
    mem[((tbl + 8 * n) >> 2) & 16383]       = a;
    mem[(((tbl + 8 * n) >> 2) + 1) & 16383] = c;
  endtask

  task automatic model(input int tbl, input int sectors, output int st);
    int left = sectors * 128;
    int p = tbl;
    exp_addr.delete();
    st = 0;
    for (int g = 0; g < 64; g++) begin
      logic [31:0] a, c;
      int w, take;
      a = mem[(p >> 2) & 16383];
      c = mem[((p >> 2) + 1) & 16383];
      w = (c[15:0] == 16'd0) ? 16384 : int'(c[15:2]);
      take = (w < left) ? w : left;
      for (int k = 0; k < take; k++) exp_addr.push_back({a[31:2], 2'b00} + 4 * k);
      left -= take;
      if (left == 0) begin
        st = (take == w && c[31]) ? 4 : 5;
        break;
      end
      if (c[31]) begin
        st = 0;
        break;
      end
      p += 8;
    end
  endtask

  task automatic wait_end(output logic [31:0] s);
    int irq_bad = 0;
    s = 32'h1;
    for (int t = 0; t < 100000; t++) begin
      rd(3'd2, s);
      if (irq !== s[2]) irq_bad++;
      if (!s[0] || s[2]) break;
    end
    chk(irq_bad == 0, "R11 irq follows status bit 2", irq_bad, 0);
  endtask

  task automatic start(input int tbl, input int sectors, input bit d2m);
    wr(3'd0, 32'd0);
    wr(3'd2, 32'd6);
    wr(3'd4, tbl);
    dev_sectors = sectors[7:0];
    wr(3'd0, d2m ? 32'h9 : 32'h1);
  endtask

  task automatic run_case(input string req, input int tbl, input int sectors, input bit d2m);
    int est, in_base, out_base, bad;
    logic [31:0] s;
    model(tbl, sectors, est);
    in_base = in_idx;
    out_base = out_q.size();
    start(tbl, sectors, d2m);
    wait_end(s);
    repeat (2) @(negedge clk);
    rd(3'd2, s);
    chk(s == est, {req, " end status"}, s, est);
    bad = 0;
    if (d2m) begin
      chk(in_idx - in_base == exp_addr.size(), {req, " R3 device words used"}, in_idx - in_base, exp_addr.size());
      foreach (exp_addr[k])
        if (mem[exp_addr[k][15:2]] !== 32'hA500_0000 + in_base + k) bad++;
      chk(bad == 0, {req, " R12 R3 data written to memory"}, bad, 0);
    end else begin
      chk(out_q.size() - out_base == exp_addr.size(), {req, " R3 words sent to device"}, out_q.size() - out_base, exp_addr.size());
      foreach (exp_addr[k])
        if (out_base + k < out_q.size() && out_q[out_base + k] !== mem[exp_addr[k][15:2]]) bad++;
      chk(bad == 0, {req, " R12 R3 data sent to device"}, bad, 0);
    end
  endtask

  initial begin
    logic [31:0] s;
    int base_in;
    for (int i = 0; i < 16384; i++) mem[i] = 32'h5A5A_0000 | i;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd(3'd0, s); chk(s == 0, "R1 command after reset", s, 0);
    rd(3'd2, s); chk(s == 0, "R1 status after reset", s, 0);
    rd(3'd4, s); chk(s == 0, "R1 base after reset", s, 0);
    chk(!irq && !mem_req, "R1 irq and request idle", {irq, mem_req}, 0);
    wr(3'd4, 32'h0000_0103);
    rd(3'd4, s); chk(s == 32'h100, "R2 base word aligned readback", s, 32'h100);

    desc(32'h100, 0, 32'h1000, 32'h8000_0200);
    run_case("R5 exact table device-to-memory", 32'h100, 1, 1'b1);
    chk(irq, "R11 irq high after exact end", irq, 1);
    wr(3'd2, 32'h4);
    rd(3'd2, s); chk(s == 0 && !irq, "R9 interrupt write-1-clear", s, 0);

    desc(32'h200, 0, 32'h2000, 32'h0000_0100);
    desc(32'h200, 1, 32'h3000, 32'h8000_0100);
    run_case("R5 two-descriptor memory-to-device", 32'h200, 1, 1'b0);

    desc(32'h300, 0, 32'h4000, 32'h8000_0010);
    run_case("R6 short table", 32'h300, 1, 1'b1);
    chk(mem[16'h4010 >> 2] == (32'h5A5A_0000 | (32'h4010 >> 2)), "R6 memory past table untouched",
        mem[16'h4010 >> 2], 32'h5A5A_0000 | (32'h4010 >> 2));
    wr(3'd0, 32'd0);
    rd(3'd2, s); chk(s == 0, "R8 stop after short table", s, 0);

    desc(32'h400, 0, 32'h5000, 32'h8000_1000);
    run_case("R7 long table", 32'h400, 1, 1'b1);
    rd(3'd0, s); chk(s == 32'h9, "R2 command readback", s, 32'h9);
    wr(3'd0, 32'd0);
    rd(3'd2, s); chk(s == 4, "R8 stop after device end keeps interrupt", s, 4);

    desc(32'h500, 0, 32'h6000, 32'h0000_0200);
    desc(32'h500, 1, 32'h7000, 32'h8000_0200);
    run_case("R7 descriptor boundary not last", 32'h500, 1, 1'b1);

    base_in = in_idx;
    start(32'h400, 1, 1'b1);
    wr(3'd0, 32'd0);
    rd(3'd2, s); chk(s == 0, "R8 mid-run stop status", s, 0);
    repeat (20) @(negedge clk);
    chk(in_idx == base_in && !mem_req, "R8 no device words after stop", in_idx - base_in, 0);

    desc(32'h600, 0, 32'h8000_0000, 32'h8000_0200);
    start(32'h600, 1, 1'b1);
    wait_end(s);
    repeat (3) @(negedge clk);
    rd(3'd2, s); chk(s == 6, "R10 error response status", s, 6);
    chk(!mem_req, "R10 no request after error", mem_req, 0);
    wr(3'd2, 32'h6);
    rd(3'd2, s); chk(s == 0, "R9 error write-1-clear", s, 0);

    desc(32'h100, 0, 32'h0000_0000, 32'h8000_0000);
    run_case("R4 zero count is 64 KiB", 32'h100, 128, 1'b0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule